// File: doc/BRIEF.md
# Three-Stage Interpolating Up-Conversion Chain

This block raises the sample rate of a real baseband stream by 128. It takes one 16-bit signed sample with 15 fractional bits per symbol period. The sample passes through three stages in a fixed order:

- a pulse-shaping FIR interpolator that doubles the rate;
- a second FIR interpolator that doubles the rate again and pre-corrects the passband droop of the stage after it;
- a five-section CIC interpolator that multiplies the rate by 32.

The output is a 36-bit full-precision sample on every clock. A small sequencer sets the cadence of all three stages. It has three named states:

- **IDLE**: waits for the first input strobe. The transition *start* (a strobe in IDLE) moves it to FILL.
- **FILL**: counts the cycles until the first CIC output is due. The transition *filled* (phase count 5) moves it to RUN.
- **RUN**: holds the output-valid flag high. It stays in RUN until reset.

A synchronous active-high reset returns the sequencer to IDLE. It also clears every delay line, comb register and integrator.

After the first accepted sample, the block takes an input once every 128 clocks, in a fixed slot. In the slot the sample is the input data if the strobe is high, and zero if it is not.

Top module: `duc_chain`

## Requirements
- R1: While reset is high, and in the cycles after reset until the first accepted sample, `out_valid` is 0 and `out_data` is 0. Reset also clears all filter state, so a later run behaves as if from power-up.
- R2: A strobe while IDLE is accepted at that clock edge (cycle P0). `out_valid` is 0 after edges P0 to P0+4. It is 1 after edge P0+5 and stays 1 until reset.
- R3: After the first accepted sample, the input is sampled only on every 128th edge counted from P0. A strobe and data on any other edge have no effect on the output.
- R4: If the strobe is low on a sampling edge, the stage-1 input for that slot is the value 0, whatever `in_data` holds.
- R5: Stage 1 keeps a line of the last 32 inputs x[n-k], k = 0..31. Its even output is the sum over k of x[n-k]·h1[2k]. Its odd output is the sum over k of x[n-k]·h1[2k+1]. h1 is the 63-tap symmetric pulse-shaping response in Q15, with centre tap 11069. Each sum is rounded as (acc + 2^14) >> 15 (arithmetic shift) and clamped to the 16-bit range.
- R6: Stage 2 applies the same polyphase, rounding and clamping rule to the stage-1 stream. It uses a line of 11 samples and the 21-tap symmetric compensation response h2 in Q15, with centre tap 12127.
- R7: Stage 3 takes five first differences of the stage-2 stream, with a delay of 1, at the stage-2 rate. It places each result followed by 31 zeros into the fast-rate stream, then integrates that stream five times. All arithmetic is modulo 2^36.
- R8: After edge P0+5+m, `out_data` equals sample m of the cascade R5→R6→R7 applied to the input slot sequence. The first sample is m = 0, and the match is exact to the bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, one output sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed Q1.15 baseband sample |
| out_valid | output | 1 | High once the pipeline has filled |
| out_data | output | 36 | Signed full-precision interpolated sample |

## Verification
The only timing reference is the edge that accepts the first sample, P0. Counted from there:

- Stage 1 registers its even output at P0+1 and its odd output at P0+65.
- Stage 2 registers its outputs at offsets 3, 35, 67 and 99 within each 128-cycle frame.
- The comb register loads at offset 4 of each 32-cycle sub-frame.
- Output sample m is visible after edge P0+5+m.

The bench drives inputs and reads outputs on falling edges only. On the falling edge after edge P0+j it compares `out_data` with model sample j-5, and it expects `out_valid` to be 0 for j below 5. The expected values come from an integer model of the cascade that is built before the run, so each comparison lands on the exact cycle in which that sample is due.

// File: rtl/duc_pkg.sv
package duc_pkg;

    localparam int SAMP_W     = 16;
    localparam int FRAC_W     = 15;
    localparam int COEF_W     = 16;
    localparam int ACC_W      = 40;
    localparam int SHAPE_TAPS = 63;
    localparam int COMP_TAPS  = 21;
    localparam int CIC_SECT   = 5;
    localparam int CIC_RLOG2  = 5;
    localparam int CIC_W      = SAMP_W + CIC_SECT * CIC_RLOG2 - CIC_RLOG2;
    localparam int PH_W       = 2 + CIC_RLOG2;

    typedef logic signed [SAMP_W-1:0] samp_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic signed [CIC_W-1:0]  wide_t;

    typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_RUN} seq_state_e;

    // Pulse-shaping response, symmetric about tap 31
    function automatic coef_t shape_half(int idx);
        int k;
        int v;
        k = (idx > (SHAPE_TAPS - 1) / 2) ? (SHAPE_TAPS - 1 - idx) : idx;
        case (k)
            0: v = 23;      1: v = 69;      2: v = -7;      3: v = -82;
            4: v = -88;     5: v = 43;      6: v = 161;     7: v = 105;
            8: v = -111;    9: v = -242;    10: v = -102;   11: v = 197;
            12: v = 324;    13: v = 95;     14: v = -292;   15: v = -423;
            16: v = -105;   17: v = 406;    18: v = 580;    19: v = 131;
            20: v = -596;   21: v = -836;   22: v = -154;   23: v = 940;
            24: v = 1278;   25: v = 161;    26: v = -1668;  27: v = -2290;
            28: v = -151;   29: v = 4420;   30: v = 9096;   31: v = 11069;
            default: v = 0;
        endcase
        return coef_t'(v);
    endfunction

    // Droop-compensation response, symmetric about tap 10
    function automatic coef_t comp_half(int idx);
        int k;
        int v;
        k = (idx > (COMP_TAPS - 1) / 2) ? (COMP_TAPS - 1 - idx) : idx;
        case (k)
            0: v = -23;     1: v = -29;     2: v = 128;     3: v = 393;
            4: v = 206;     5: v = -875;    6: v = -1940;   7: v = -777;
            8: v = 3758;    9: v = 9486;    10: v = 12127;
            default: v = 0;
        endcase
        return coef_t'(v);
    endfunction

    function automatic coef_t coef_of(int bank, int idx);
        int taps;
        taps = (bank == 0) ? SHAPE_TAPS : COMP_TAPS;
        if (idx < 0 || idx >= taps) return '0;
        return (bank == 0) ? shape_half(idx) : comp_half(idx);
    endfunction

    function automatic samp_t round_sat(acc_t a);
        acc_t r;
        r = (a + acc_t'(2 ** (FRAC_W - 1))) >>> FRAC_W;
        if (r > acc_t'(2 ** (SAMP_W - 1) - 1)) return {1'b0, {(SAMP_W-1){1'b1}}};
        if (r < -acc_t'(2 ** (SAMP_W - 1)))    return {1'b1, {(SAMP_W-1){1'b0}}};
        return r[SAMP_W-1:0];
    endfunction

endpackage

// File: rtl/duc_fir_interp.sv
module duc_fir_interp
    import duc_pkg::*;
#(
    parameter int NTAPS = SHAPE_TAPS,
    parameter int BANK  = 0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  shift,
    input  samp_t din,
    input  logic  emit,
    input  logic  odd,
    output samp_t y
);
    localparam int DEPTH = (NTAPS + 1) / 2;

    samp_t line_q [DEPTH];
    acc_t  prod_e [DEPTH];
    acc_t  prod_o [DEPTH];
    acc_t  acc;
    samp_t y_q;

    for (genvar k = 0; k < DEPTH; k++) begin : g_tap
        localparam coef_t CE = coef_of(BANK, 2 * k);
        localparam coef_t CO = coef_of(BANK, 2 * k + 1);
        assign prod_e[k] = acc_t'(line_q[k]) * acc_t'(CE);
        assign prod_o[k] = acc_t'(line_q[k]) * acc_t'(CO);
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < DEPTH; k++) begin
            acc = acc + (odd ? prod_o[k] : prod_e[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) line_q[k] <= '0;
            y_q <= '0;
        end else begin
            if (shift) begin
                line_q[0] <= din;
                for (int k = 1; k < DEPTH; k++) line_q[k] <= line_q[k-1];
            end
            if (emit) y_q <= round_sat(acc);
        end
    end

    assign y = y_q;

endmodule

// File: rtl/duc_cic_interp.sv
module duc_cic_interp
    import duc_pkg::*;
#(
    parameter int SECT = CIC_SECT
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  samp_t din,
    input  logic  stuff,
    output wide_t y
);
    wide_t dly_q [SECT];
    wide_t diff  [SECT+1];
    wide_t integ_q [SECT];
    wide_t sum   [SECT+1];
    wide_t comb_q;

    always_comb begin
        diff[0] = wide_t'(din);
        for (int i = 0; i < SECT; i++) diff[i+1] = diff[i] - dly_q[i];
        sum[0] = stuff ? comb_q : '0;
        for (int i = 0; i < SECT; i++) sum[i+1] = integ_q[i] + sum[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SECT; i++) begin
                dly_q[i]   <= '0;
                integ_q[i] <= '0;
            end
            comb_q <= '0;
        end else begin
            if (load) begin
                for (int i = 0; i < SECT; i++) dly_q[i] <= diff[i];
                comb_q <= diff[SECT];
            end
            for (int i = 0; i < SECT; i++) integ_q[i] <= sum[i+1];
        end
    end

    assign y = integ_q[SECT-1];

endmodule

// File: rtl/duc_seq.sv
module duc_seq
    import duc_pkg::*;
#(
    parameter int RLOG2 = CIC_RLOG2
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic take,
    output logic s1_emit,
    output logic s1_odd,
    output logic s2_shift,
    output logic s2_emit,
    output logic s2_odd,
    output logic comb_en,
    output logic stuff,
    output logic run
);
    localparam int W         = 2 + RLOG2;
    localparam int S1_AT     = 1;
    localparam int S2_SH_AT  = 2;
    localparam int S2_EM_AT  = 3;
    localparam int COMB_AT   = 4;
    localparam int STUFF_AT  = 5;

    seq_state_e       state_q, state_d;
    logic [W-1:0]     ph_q, ph_d;
    logic [RLOG2-1:0] sub;

    assign sub = ph_q[RLOG2-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ph_q    <= '0;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
        end
    end

    always_comb begin
        state_d = state_q;
        ph_d    = ph_q + W'(1);
        unique case (state_q)
            ST_IDLE: begin
                ph_d = in_valid ? W'(1) : '0;
                if (in_valid) state_d = ST_FILL;
            end
            ST_FILL: begin
                if (ph_q == W'(STUFF_AT)) state_d = ST_RUN;
            end
            ST_RUN: begin
                state_d = ST_RUN;
            end
            default: begin
                state_d = ST_IDLE;
                ph_d    = '0;
            end
        endcase
    end

    always_comb begin
        take     = 1'b0;
        s1_emit  = 1'b0;
        s1_odd   = ph_q[W-1];
        s2_shift = 1'b0;
        s2_emit  = 1'b0;
        s2_odd   = ph_q[RLOG2];
        comb_en  = 1'b0;
        stuff    = 1'b0;
        run      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                take = in_valid;
            end
            ST_FILL, ST_RUN: begin
                take     = (ph_q == '0);
                s1_emit  = (ph_q[W-2:0] == (W-1)'(S1_AT));
                s2_shift = (ph_q[W-2:0] == (W-1)'(S2_SH_AT));
                s2_emit  = (sub == RLOG2'(S2_EM_AT));
                comb_en  = (sub == RLOG2'(COMB_AT));
                stuff    = (sub == RLOG2'(STUFF_AT));
                run      = (state_q == ST_RUN);
            end
            default: begin
                take = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/duc_chain.sv
module duc_chain
    import duc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [SAMP_W-1:0] in_data,
    output logic                     out_valid,
    output logic signed [CIC_W-1:0]  out_data
);
    logic  take, s1_emit, s1_odd, s2_shift, s2_emit, s2_odd, comb_en, stuff, run;
    samp_t shape_din, s1_y, s2_y;
    wide_t cic_y;

    assign shape_din = in_valid ? in_data : '0;

    duc_seq #(.RLOG2(CIC_RLOG2)) u_seq (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .take(take), .s1_emit(s1_emit), .s1_odd(s1_odd),
        .s2_shift(s2_shift), .s2_emit(s2_emit), .s2_odd(s2_odd),
        .comb_en(comb_en), .stuff(stuff), .run(run)
    );

    duc_fir_interp #(.NTAPS(SHAPE_TAPS), .BANK(0)) u_shape (
        .clk(clk), .rst(rst), .shift(take), .din(shape_din),
        .emit(s1_emit), .odd(s1_odd), .y(s1_y)
    );

    duc_fir_interp #(.NTAPS(COMP_TAPS), .BANK(1)) u_comp (
        .clk(clk), .rst(rst), .shift(s2_shift), .din(s1_y),
        .emit(s2_emit), .odd(s2_odd), .y(s2_y)
    );

    duc_cic_interp #(.SECT(CIC_SECT)) u_cic (
        .clk(clk), .rst(rst), .load(comb_en), .din(s2_y),
        .stuff(stuff), .y(cic_y)
    );

    assign out_valid = run;
    assign out_data  = cic_y;

endmodule

// File: rtl/duc_chain_chk.sv
module duc_chain_chk
    import duc_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    take,
    input logic                    out_valid,
    input logic signed [CIC_W-1:0] out_data,
    input logic                    s1_emit,
    input logic signed [SAMP_W-1:0] s1_y,
    input logic                    s2_emit,
    input logic signed [SAMP_W-1:0] s2_y
);
    logic       seen_q;
    logic [7:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            gap_q  <= '0;
        end else if (take) begin
            seen_q <= 1'b1;
            gap_q  <= '0;
        end else if (gap_q != 8'hFF) begin
            gap_q <= gap_q + 8'd1;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

    // R2
    valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> out_valid);

    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid, 6));

    // R3
    slot_gap_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> (!seen_q || gap_q == 8'd127));

    // R5
    shape_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !s1_emit |=> $stable(s1_y));

    // R6
    comp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !s2_emit |=> $stable(s2_y));

endmodule

bind duc_chain duc_chain_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .take(take),
    .out_valid(out_valid), .out_data(out_data),
    .s1_emit(s1_emit), .s1_y(s1_y), .s2_emit(s2_emit), .s2_y(s2_y)
);

// File: tb/duc_chain_tb.sv
module duc_chain_tb;
    import duc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NSLOT      = 52;
    localparam int NOUT       = NSLOT * 128;
    localparam int NCHIRP     = 40;
    localparam logic signed [15:0] EDGE_VEC [8] =
        '{16'sh7FFF, 16'sh8000, 16'sh7FFF, 16'sh8000,
          16'sh7FFF, 16'sh7FFF, 16'sh8000, 16'sh0000};

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic rst, in_valid, out_valid;
    logic signed [SAMP_W-1:0] in_data;
    logic signed [CIC_W-1:0]  out_data;

    int checks = 0;
    int fails  = 0;

    longint xs  [NSLOT];
    bit     xv  [NSLOT];
    longint s1m [2*NSLOT];
    longint s2m [4*NSLOT];
    longint cm  [4*NSLOT];
    longint ym  [NOUT];

    duc_chain u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic longint rq(longint a);
        longint r;
        r = (a + 64'sd16384) >>> 15;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    // Behavioural cascade: R4 zero slots, R5, R6, R7
    task automatic build_model();
        for (int m = 0; m < 2*NSLOT; m++) begin
            longint acc = 0;
            for (int k = 0; 2*k + (m % 2) < SHAPE_TAPS; k++)
                if (m/2 - k >= 0)
                    acc += longint'(coef_of(0, 2*k + (m % 2))) * xs[m/2 - k];
            s1m[m] = rq(acc);
        end
        for (int m = 0; m < 4*NSLOT; m++) begin
            longint acc = 0;
            for (int k = 0; 2*k + (m % 2) < COMP_TAPS; k++)
                if (m/2 - k >= 0)
                    acc += longint'(coef_of(1, 2*k + (m % 2))) * s1m[m/2 - k];
            s2m[m] = rq(acc);
        end
        for (int j = 0; j < 4*NSLOT; j++) cm[j] = s2m[j];
        for (int s = 0; s < CIC_SECT; s++)
            for (int j = 4*NSLOT - 1; j > 0; j--) cm[j] = cm[j] - cm[j-1];
        for (int k = 0; k < NOUT; k++) ym[k] = (k % 32 == 0) ? cm[k/32] : 0;
        for (int s = 0; s < CIC_SECT; s++)
            for (int k = 1; k < NOUT; k++) ym[k] = ym[k] + ym[k-1];
    endtask

    // Drives the slot sequence and checks every output on falling edges
    task automatic run_stream();
        build_model();
        for (int j = 0; j < NOUT + 5; j++) begin
            @(negedge clk);
            if (j >= 1) begin
                if (j - 1 >= 5) begin
                    chk(out_valid == 1'b1, "R2 valid held", longint'(out_valid), 1);
                    chk(longint'(out_data) == ym[j-6], "R8 R5 R6 R7 R4 R3 sample",
                        longint'(out_data), ym[j-6]);
                end else begin
                    chk(out_valid == 1'b0, "R2 valid during fill", longint'(out_valid), 0);
                end
            end
            if (j % 128 == 0 && j / 128 < NSLOT) begin
                in_valid = xv[j/128];
                in_data  = xv[j/128] ? samp_t'(xs[j/128]) : 16'sh5A5A;
            end else if (j % 128 == 37 && (j / 128) % 3 == 1) begin
                in_valid = 1'b1;
                in_data  = 16'sh7123;
            end else begin
                in_valid = 1'b0;
                in_data  = samp_t'(j * 977);
            end
        end
        in_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL R8 watchdog: got %0d expected %0d", 1, 0);
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        in_data = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 reset valid", longint'(out_valid), 0);
        chk(out_data == '0, "R1 reset data", longint'(out_data), 0);
        rst = 1'b0;
        for (int i = 0; i < 10; i++) begin
            in_data = samp_t'(i * 3001);
            @(negedge clk);
            chk(out_valid == 1'b0, "R1 idle valid", longint'(out_valid), 0);
            chk(out_data == '0, "R1 idle data", longint'(out_data), 0);
        end

        // Run A: swept tone, full-scale vectors, skipped slots (R4), stray strobes (R3)
        for (int n = 0; n < NSLOT; n++) begin
            if (n < NCHIRP)
                xs[n] = longint'($rtoi(29000.0 * $sin(3.14159265 * 0.02 * n * n)));
            else if (n < NCHIRP + 8)
                xs[n] = longint'(EDGE_VEC[n - NCHIRP]);
            else
                xs[n] = 0;
            xv[n] = (n < NCHIRP + 8) && (n % 11 != 5);
            if (!xv[n]) xs[n] = 0;
        end
        run_stream();

        // Mid-stream reset clears everything (R1)
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 mid reset valid", longint'(out_valid), 0);
        chk(out_data == '0, "R1 mid reset data", longint'(out_data), 0);
        rst = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R1 post reset valid", longint'(out_valid), 0);
            chk(out_data == '0, "R1 post reset data", longint'(out_data), 0);
        end

        // Run B: impulse after reset, no trace of run A may remain (R1, R2, R8)
        for (int n = 0; n < NSLOT; n++) begin
            xs[n] = (n == 0) ? 64'sd16384 : 64'sd0;
            xv[n] = (n < 4);
        end
        run_stream();

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule